// File: doc/BRIEF.md
# Recency Stack with Positional Insertion

This block keeps the replacement ordering of one set in a set-associative cache. Each way carries a small stack position. The top value, WAYS-1, marks the most recently used line, and zero marks the least recently used line. A hit moves the named way to the top and closes the gap it leaves behind. A fill replaces the way at position zero. The new line can be placed at any depth of the stack rather than always at the top. Only the lines lying between the bottom and that depth move down by one.

A replacement controller supplies the insertion depth and decides it outside this block. The controller reads the victim way combinationally, and it issues at most one hit or one fill per cycle. Tags, data and the policy that picks the depth are handled elsewhere. When both strobes arrive in the same cycle, the cycle is flagged and ignored.

Top module: `recency_stack`

## Requirements
- R1: After reset, way i holds position i for every way.
- R2: A hit to way w (with no fill) sets w to position WAYS-1 (15 by default) at the next clock edge.
- R3: On a hit to way w at position p, every other way whose position is above p drops by one, and every way below p keeps its position.
- R4: A fill with insertion depth q gives the way that held position 0 the position q at the next clock edge.
- R5: On a fill with depth q, every way at positions 1 to q drops by one, and every way above q keeps its position.
- R6: The victim way output names the way whose position is 0, combinationally from the current state.
- R7: The per-way positions are always a permutation of 0 to WAYS-1.
- R8: When hit and fill are asserted together, the conflict output is high in that cycle and no position changes.
- R9: A fill with depth 0 leaves every position unchanged.
- R10: A hit to the way already at position WAYS-1 leaves every position unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | Hit strobe |
| hit_way_i | input | PW (4) | Way that hit |
| fill_i | input | 1 | Fill strobe; replaces the victim way |
| ins_pos_i | input | PW (4) | Stack depth for the new line, 0 = bottom, WAYS-1 = top |
| victim_way_o | output | PW (4) | Way at position 0 |
| pos_o | output | WAYS*PW (64) | Positions; way i in bits [i*PW +: PW] |
| conflict_o | output | 1 | High when hit_i and fill_i are both set |

## Verification
Random hits to arbitrary ways show that promotion shifts only the lines above the hit depth. Hits to the bottom way and to the top way separate a full rotation from a no-op. Fills cover random depths together with the extremes 0 and WAYS-1. These tell apart an off-by-one in the shifted range, a victim that fails to move, and a top-only insertion. Simultaneous strobes check that a conflicting cycle raises the flag and freezes the state. A reference model in the bench tracks every way after each operation, and the output is rechecked as a permutation every time.

// File: rtl/recstk_pkg.sv
package recstk_pkg;
   typedef enum logic [1:0] {
      OP_IDLE     = 2'd0,
      OP_HIT      = 2'd1,
      OP_FILL     = 2'd2,
      OP_CONFLICT = 2'd3
   } recstk_op_e;

   function automatic recstk_op_e recstk_decode(input logic hit, input logic fill);
      recstk_op_e op;
      unique case ({hit, fill})
         2'b10:   op = OP_HIT;
         2'b01:   op = OP_FILL;
         2'b11:   op = OP_CONFLICT;
         default: op = OP_IDLE;
      endcase
      return op;
   endfunction
endpackage

// File: rtl/recstk_cell.sv
module recstk_cell
   import recstk_pkg::*;
#(
   parameter int PW        = 4,
   parameter int RESET_POS = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  recstk_op_e    op,
   input  logic          hit_sel,
   input  logic          victim_sel,
   input  logic [PW-1:0] hit_pos,
   input  logic [PW-1:0] ins_pos,
   output logic [PW-1:0] pos_o
);
   localparam logic [PW-1:0] TOP = {PW{1'b1}};

   logic [PW-1:0] pos_q, pos_d;

   always_comb begin
      pos_d = pos_q;
      unique case (op)
         OP_HIT: begin
            if (hit_sel)              pos_d = TOP;
            else if (pos_q > hit_pos) pos_d = pos_q - 1'b1;
         end
         OP_FILL: begin
            if (victim_sel)                          pos_d = ins_pos;
            else if (pos_q != '0 && pos_q <= ins_pos) pos_d = pos_q - 1'b1;
         end
         default: pos_d = pos_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= PW'(RESET_POS);
      else        pos_q <= pos_d;
   end

   assign pos_o = pos_q;

   a_r2_hit_to_top: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_HIT && hit_sel) |=> (pos_o == TOP));

   a_r4_victim_takes_depth: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_FILL && victim_sel) |=> (pos_o == $past(ins_pos)));

   a_r3_below_hit_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_HIT && !hit_sel && pos_o < hit_pos) |=> $stable(pos_o));
endmodule

// File: rtl/recstk_victim.sv
module recstk_victim #(
   parameter int WAYS = 16,
   parameter int PW   = 4
) (
   input  logic [WAYS-1:0][PW-1:0] pos_i,
   output logic [PW-1:0]           way_o,
   output logic [WAYS-1:0]         sel_o
);
   always_comb begin
      way_o = '0;
      for (int i = 0; i < WAYS; i++) begin
         sel_o[i] = (pos_i[i] == '0);
         if (sel_o[i]) way_o = way_o | PW'(i);
      end
   end
endmodule

// File: rtl/recency_stack.sv
module recency_stack
   import recstk_pkg::*;
#(
   parameter int WAYS = 16,
   parameter int PW   = $clog2(WAYS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit_i,
   input  logic [PW-1:0]      hit_way_i,
   input  logic               fill_i,
   input  logic [PW-1:0]      ins_pos_i,
   output logic [PW-1:0]      victim_way_o,
   output logic [WAYS*PW-1:0] pos_o,
   output logic               conflict_o
);
   localparam logic [PW-1:0] TOP = {PW{1'b1}};

   if (WAYS < 2 || (1 << PW) != WAYS) begin : g_bad_cfg
      $error("recency_stack: WAYS must be a power of two of at least 2 and PW its log2");
   end

   recstk_op_e                op;
   logic [WAYS-1:0][PW-1:0]   pos_w;
   logic [WAYS-1:0]           victim_sel;
   logic [PW-1:0]             hit_pos;

   assign op         = recstk_decode(hit_i, fill_i);
   assign conflict_o = (op == OP_CONFLICT);
   assign hit_pos    = pos_w[hit_way_i];

   recstk_victim #(.WAYS(WAYS), .PW(PW)) u_victim (
      .pos_i (pos_w),
      .way_o (victim_way_o),
      .sel_o (victim_sel)
   );

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      recstk_cell #(.PW(PW), .RESET_POS(g)) u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .op         (op),
         .hit_sel    (hit_way_i == PW'(g)),
         .victim_sel (victim_sel[g]),
         .hit_pos    (hit_pos),
         .ins_pos    (ins_pos_i),
         .pos_o      (pos_w[g])
      );
   end

   assign pos_o = pos_w;

   logic [WAYS-1:0] seen;
   always_comb begin
      seen = '0;
      for (int i = 0; i < WAYS; i++) seen[pos_w[i]] = 1'b1;
   end

   a_r7_permutation: assert property (@(posedge clk) disable iff (!rst_n)
      (seen == {WAYS{1'b1}}));

   a_r8_conflict_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i && fill_i) |=> $stable(pos_o));

   a_r9_fill_bottom_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_i && !hit_i && ins_pos_i == '0) |=> $stable(pos_o));

   a_r10_top_hit_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i && !fill_i && hit_pos == TOP) |=> $stable(pos_o));
endmodule

// File: tb/recency_stack_tb.sv
`timescale 1ns/1ps
module recency_stack_tb;
   localparam int WAYS = 16;
   localparam int PW   = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               hit_i = 1'b0;
   logic [PW-1:0]      hit_way_i = '0;
   logic               fill_i = 1'b0;
   logic [PW-1:0]      ins_pos_i = '0;
   logic [PW-1:0]      victim_way_o;
   logic [WAYS*PW-1:0] pos_o;
   logic               conflict_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   int m [WAYS];

   always #2 clk = ~clk;

   recency_stack #(.WAYS(WAYS), .PW(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .hit_way_i(hit_way_i),
      .fill_i(fill_i), .ins_pos_i(ins_pos_i), .victim_way_o(victim_way_o),
      .pos_o(pos_o), .conflict_o(conflict_o)
   );

   function automatic int dut_pos(input int w);
      return int'(pos_o[w*PW +: PW]);
   endfunction

   function automatic int model_victim();
      for (int i = 0; i < WAYS; i++) if (m[i] == 0) return i;
      return -1;
   endfunction

   function automatic void model_hit(input int w);
      int p = m[w];
      for (int i = 0; i < WAYS; i++) if (i != w && m[i] > p) m[i] = m[i] - 1;
      m[w] = WAYS - 1;
   endfunction

   function automatic void model_fill(input int q);
      int v = model_victim();
      for (int i = 0; i < WAYS; i++) if (m[i] >= 1 && m[i] <= q) m[i] = m[i] - 1;
      m[v] = q;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_state(input string tag);
      bit [WAYS-1:0] seen = '0;
      for (int i = 0; i < WAYS; i++) begin
         check(tag, dut_pos(i), m[i]);
         seen[dut_pos(i)] = 1'b1;
      end
      check("R7 permutation", int'(seen == {WAYS{1'b1}}), 1);
   endtask

   task automatic do_hit(input int w, input string tag);
      check("R6 victim", int'(victim_way_o), model_victim());
      hit_i = 1'b1; hit_way_i = PW'(w);
      @(negedge clk);
      hit_i = 1'b0;
      model_hit(w);
      check_state(tag);
   endtask

   task automatic do_fill(input int q, input string tag);
      check("R6 victim", int'(victim_way_o), model_victim());
      fill_i = 1'b1; ins_pos_i = PW'(q);
      @(negedge clk);
      fill_i = 1'b0;
      model_fill(q);
      check_state(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      int seed;
      seed = $urandom(32'd2024);
      for (int i = 0; i < WAYS; i++) m[i] = i;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 reset");

      do_hit(WAYS - 1, "R10 top hit");
      do_hit(0, "R2 R3 bottom hit");
      do_fill(0, "R9 fill depth 0");
      do_fill(WAYS - 1, "R4 R5 fill top");
      do_fill(WAYS / 2, "R4 R5 fill middle");
      do_fill(1, "R4 R5 fill near bottom");

      hit_i = 1'b1; hit_way_i = 4'd3; fill_i = 1'b1; ins_pos_i = 4'd7;
      #1;
      check("R8 conflict flag", int'(conflict_o), 1);
      @(negedge clk);
      hit_i = 1'b0; fill_i = 1'b0;
      #1;
      check("R8 conflict clear", int'(conflict_o), 0);
      check_state("R8 frozen");

      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(1, 0) == 1)
            do_hit(int'($urandom_range(WAYS - 1, 0)), "R2 R3 random hit");
         else
            do_fill(int'($urandom_range(WAYS - 1, 0)), "R4 R5 random fill");
      end
      finish_run();
   end
endmodule